// File: doc/BRIEF.md
# Flash command controller with region locks

This block sequences operations on a small on-chip flash array, held inside the block as a register array of pages. Software first fills a page buffer through a 128-bit chunk write port. It then writes a single command word that carries a key, an opcode and an argument. The controller checks the key, the argument range and the lock state of the affected region. A command that passes these checks runs for a fixed number of cycles. A command that fails them is rejected and flagged.

The operations are page programming, whole-array erase, plane erase, and region lock and unlock. Programming ANDs the buffer into the page and then refills the buffer with all ones. An erased page can therefore be filled in several passes, each pass covering different 128-bit chunks. A status word gives the ready, command-error and lock-error flags. A mode bit gates a ready interrupt, and a read port exposes the array contents.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The command word is laid out as key in bits 31:24, argument in bits 23:8 and opcode in bits 7:0. A command whose key is not 8'hA5 does not execute: it sets command-error and leaves the ready flag high.
- R2: Opcode 8'h01 programs the page named by the argument. Each word of the page becomes its old value ANDed with the matching buffer word. The buffer then returns to all ones, so a page can be programmed in several steps with each earlier step preserved.
- R3: The buffer is loaded in 128-bit chunks. Chunk c covers page words 4c to 4c+3, and the lowest 32 bits of the chunk go to word 4c. The erased and reset value of every array word and buffer word is all ones.
- R4: Programming a page inside a locked region leaves the array unchanged, sets lock-error and keeps ready high.
- R5: Opcode 8'h02 sets every word of the array to all ones. It is rejected with lock-error while any region is locked.
- R6: Opcode 8'h03 erases every page of the plane named by the argument. Plane p holds pages 8p to 8p+7. The command is rejected with lock-error if any region in that plane is locked.
- R7: Opcode 8'h04 locks, and opcode 8'h05 unlocks, the region that contains the page named by the argument. Region r holds pages 4r to 4r+3, and lockState bit r shows its lock.
- R8: An accepted command drives ready low on the next clock edge. Ready stays low for exactly 6 cycles. The new array or lock contents are visible in the cycle in which ready returns high.
- R9: irq equals ready ANDed with the interrupt enable. The enable is bit 0 of the mode register and is written through modeWrEn.
- R10: status bit 0 is ready, bit 1 is command-error and bit 2 is lock-error. A status read pulse clears both error flags. Every new command replaces both error flags with the result of its own checks.
- R11: A command written while ready is low is ignored: the running operation finishes unaltered and command-error is set.
- R12: An unknown opcode, a page argument of 16 or more, or a plane argument of 2 or more sets command-error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufWrEn | input | 1 | Page buffer chunk write strobe |
| bufChunk | input | 2 | Index of the buffer chunk to write |
| bufData | input | 128 | Chunk data |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWord | input | 32 | Command word: key, argument, opcode |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 1 | Ready interrupt enable value |
| statusRdEn | input | 1 | Status read pulse; clears the error flags |
| status | output | 3 | {lock-error, command-error, ready} |
| irq | output | 1 | Ready interrupt |
| lockState | output | 4 | Lock bit per region |
| rdAddr | input | 8 | Array word address: page in the upper bits, word in the lower bits |
| rdData | output | 32 | Array word at rdAddr |

## Verification
The hardest case to reach is a second command that arrives while an operation is still running. It needs a valid, accepted command followed within six cycles by another write. The random stream never produces that, because it always waits for ready. A directed sequence therefore issues a page program and, one cycle later, a whole-array erase. It then checks that only the programming took effect. Lock rejection of plane and whole-array erase is reached by locking a region in plane 0 and then aiming erases at both planes. Random commands with occasional bad keys, bad opcodes and out-of-range arguments run against a bench model of the array.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [7:0] CMD_KEY = 8'hA5;

  typedef enum logic [7:0] {
    OP_WRITE_PAGE  = 8'h01,
    OP_ERASE_ALL   = 8'h02,
    OP_ERASE_PLANE = 8'h03,
    OP_LOCK        = 8'h04,
    OP_UNLOCK      = 8'h05
  } opcode_e;

  // control -> datapath strobes, each valid for the single finishing cycle
  typedef struct packed {
    logic doProgram;
    logic doEraseAll;
    logic doErasePlane;
  } strobe_t;
endpackage

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
  import fcc_pkg::*;
#(
  parameter int NUM_PAGES        = 16,
  parameter int PAGES_PER_REGION = 4,
  parameter int PAGES_PER_PLANE  = 8,
  parameter int OP_CYCLES        = 6,
  localparam int PAGE_IDX_W  = $clog2(NUM_PAGES),
  localparam int NUM_REGIONS = NUM_PAGES / PAGES_PER_REGION,
  localparam int NUM_PLANES  = NUM_PAGES / PAGES_PER_PLANE
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdWrEn,
  input  logic [31:0]            cmdWord,
  input  logic                   modeWrEn,
  input  logic                   modeWrData,
  input  logic                   statusRdEn,
  output logic                   ready,
  output logic                   cmdErr,
  output logic                   lockErr,
  output logic                   irq,
  output logic [NUM_REGIONS-1:0] lockState,
  output strobe_t                strobe,
  output logic [PAGE_IDX_W-1:0]  opPage
);
  localparam int REGION_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int REGION_SHIFT = $clog2(PAGES_PER_REGION);
  localparam int CNT_W        = $clog2(OP_CYCLES + 1);

  logic                   readyQ, cmdErrQ, lockErrQ, irqEnQ;
  logic [CNT_W-1:0]       cntQ;
  opcode_e                opQ;
  logic [PAGE_IDX_W-1:0]  pageQ;
  logic [NUM_REGIONS-1:0] lockQ;

  logic [7:0]            keyField, opField;
  logic [15:0]           argField;
  logic [PAGE_IDX_W-1:0] argPage;
  logic                  pageInRange, planeInRange, planeLocked;
  logic                  accept, setCmdErr, setLockErr, finish;
  logic [PAGE_IDX_W-1:0] nextPage;

  function automatic logic [REGION_W-1:0] regionOf(input logic [PAGE_IDX_W-1:0] p);
    return REGION_W'(p >> REGION_SHIFT);
  endfunction

  assign keyField     = cmdWord[31:24];
  assign argField     = cmdWord[23:8];
  assign opField      = cmdWord[7:0];
  assign argPage      = PAGE_IDX_W'(argField);
  assign pageInRange  = 32'(argField) < NUM_PAGES;
  assign planeInRange = 32'(argField) < NUM_PLANES;

  always_comb begin
    planeLocked = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (lockQ[r] && ((r * PAGES_PER_REGION) / PAGES_PER_PLANE) == 32'(argField))
        planeLocked = 1'b1;
    end
  end

  // command checking: key, readiness, opcode, argument range, locks
  always_comb begin
    accept     = 1'b0;
    setCmdErr  = 1'b0;
    setLockErr = 1'b0;
    nextPage   = argPage;
    if (cmdWrEn) begin
      if (!readyQ || keyField != CMD_KEY) begin
        setCmdErr = 1'b1;
      end else begin
        case (opField)
          OP_WRITE_PAGE: begin
            if (!pageInRange)                  setCmdErr  = 1'b1;
            else if (lockQ[regionOf(argPage)]) setLockErr = 1'b1;
            else                               accept     = 1'b1;
          end
          OP_ERASE_ALL: begin
            if (|lockQ) setLockErr = 1'b1;
            else        accept     = 1'b1;
          end
          OP_ERASE_PLANE: begin
            nextPage = PAGE_IDX_W'(32'(argField) * PAGES_PER_PLANE);
            if (!planeInRange)    setCmdErr  = 1'b1;
            else if (planeLocked) setLockErr = 1'b1;
            else                  accept     = 1'b1;
          end
          OP_LOCK, OP_UNLOCK: begin
            if (!pageInRange) setCmdErr = 1'b1;
            else              accept    = 1'b1;
          end
          default: setCmdErr = 1'b1;
        endcase
      end
    end
  end

  assign finish = !readyQ && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ   <= 1'b1;
      cntQ     <= '0;
      opQ      <= OP_WRITE_PAGE;
      pageQ    <= '0;
      lockQ    <= '0;
      cmdErrQ  <= 1'b0;
      lockErrQ <= 1'b0;
      irqEnQ   <= 1'b0;
    end else begin
      if (modeWrEn) irqEnQ <= modeWrData;

      if (cmdWrEn) begin
        cmdErrQ  <= setCmdErr;
        lockErrQ <= setLockErr;
      end else if (statusRdEn) begin
        cmdErrQ  <= 1'b0;
        lockErrQ <= 1'b0;
      end

      if (accept) begin
        readyQ <= 1'b0;
        cntQ   <= CNT_W'(OP_CYCLES - 1);
        opQ    <= opcode_e'(opField);
        pageQ  <= nextPage;
      end else if (finish) begin
        readyQ <= 1'b1;
        if (opQ == OP_LOCK)   lockQ[regionOf(pageQ)] <= 1'b1;
        if (opQ == OP_UNLOCK) lockQ[regionOf(pageQ)] <= 1'b0;
      end else if (!readyQ) begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign strobe.doProgram    = finish && (opQ == OP_WRITE_PAGE);
  assign strobe.doEraseAll   = finish && (opQ == OP_ERASE_ALL);
  assign strobe.doErasePlane = finish && (opQ == OP_ERASE_PLANE);
  assign opPage    = pageQ;
  assign ready     = readyQ;
  assign cmdErr    = cmdErrQ;
  assign lockErr   = lockErrQ;
  assign lockState = lockQ;
  assign irq       = readyQ & irqEnQ;

  // R1: a bad key never starts an operation
  p_key_reject_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && readyQ && cmdWord[31:24] != CMD_KEY) |=> (readyQ && cmdErrQ));

  // R4: a new lock error is only ever raised while nothing is running
  p_lock_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockErrQ) |-> readyQ);

  // R8: ready only falls in response to a command write
  p_ready_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyQ) |-> $past(cmdWrEn));

  // R8: the operation counter stays inside its window
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    !readyQ |-> (32'(cntQ) < OP_CYCLES));

  // R11: a command during a running operation is refused and the run continues
  p_busy_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !readyQ && cntQ != '0) |=> (!readyQ && cmdErrQ));
endmodule

// File: rtl/fcc_datapath.sv
module fcc_datapath
  import fcc_pkg::*;
#(
  parameter int NUM_PAGES       = 16,
  parameter int PAGE_WORDS      = 16,
  parameter int PAGES_PER_PLANE = 8,
  localparam int PAGE_IDX_W  = $clog2(NUM_PAGES),
  localparam int WORD_W      = $clog2(PAGE_WORDS),
  localparam int ADDR_W      = PAGE_IDX_W + WORD_W,
  localparam int NUM_CHUNKS  = PAGE_WORDS / 4,
  localparam int CHUNK_W     = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bufWrEn,
  input  logic [CHUNK_W-1:0]    bufChunk,
  input  logic [127:0]          bufData,
  input  strobe_t               strobe,
  input  logic [PAGE_IDX_W-1:0] opPage,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [31:0]           rdData
);
  localparam int TOTAL_WORDS = NUM_PAGES * PAGE_WORDS;
  localparam int PLANE_WORDS = PAGES_PER_PLANE * PAGE_WORDS;

  logic [31:0]                        memQ [TOTAL_WORDS];
  logic [NUM_CHUNKS-1:0][127:0]       chunkQ;
  logic [PAGE_WORDS-1:0][31:0]        bufWords;
  logic [ADDR_W-1:0]                  pageBase;

  assign bufWords = chunkQ;
  assign pageBase = {opPage, {WORD_W{1'b0}}};

  // page buffer: chunk loads, refilled with ones after every program
  always_ff @(posedge clk) begin
    if (!rstN || strobe.doProgram) chunkQ <= '1;
    else if (bufWrEn)              chunkQ[bufChunk] <= bufData;
  end

  // array: AND-programming and erases
  always_ff @(posedge clk) begin
    if (!rstN || strobe.doEraseAll) begin
      for (int a = 0; a < TOTAL_WORDS; a++) memQ[ADDR_W'(a)] <= '1;
    end else if (strobe.doErasePlane) begin
      for (int a = 0; a < PLANE_WORDS; a++) memQ[pageBase + ADDR_W'(a)] <= '1;
    end else if (strobe.doProgram) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        memQ[{opPage, WORD_W'(w)}] <= memQ[{opPage, WORD_W'(w)}] & bufWords[WORD_W'(w)];
    end
  end

  assign rdData = memQ[rdAddr];

  // R8: at most one array operation completes in any cycle
  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doProgram, strobe.doEraseAll, strobe.doErasePlane}));

  // R4: without a completing operation a word read twice does not change
  p_array_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doProgram || strobe.doEraseAll || strobe.doErasePlane)
      |=> (!$stable(rdAddr) || $stable(rdData)));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int NUM_PAGES        = 16,
  parameter int PAGE_WORDS       = 16,
  parameter int PAGES_PER_REGION = 4,
  parameter int PAGES_PER_PLANE  = 8,
  parameter int OP_CYCLES        = 6,
  localparam int PAGE_IDX_W  = $clog2(NUM_PAGES),
  localparam int ADDR_W      = PAGE_IDX_W + $clog2(PAGE_WORDS),
  localparam int NUM_REGIONS = NUM_PAGES / PAGES_PER_REGION,
  localparam int NUM_CHUNKS  = PAGE_WORDS / 4,
  localparam int CHUNK_W     = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bufWrEn,
  input  logic [CHUNK_W-1:0]     bufChunk,
  input  logic [127:0]           bufData,
  input  logic                   cmdWrEn,
  input  logic [31:0]            cmdWord,
  input  logic                   modeWrEn,
  input  logic                   modeWrData,
  input  logic                   statusRdEn,
  output logic [2:0]             status,
  output logic                   irq,
  output logic [NUM_REGIONS-1:0] lockState,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [31:0]            rdData
);
  strobe_t               strobe;
  logic [PAGE_IDX_W-1:0] opPage;
  logic                  ready, cmdErr, lockErr;

  fcc_ctrl #(
    .NUM_PAGES(NUM_PAGES), .PAGES_PER_REGION(PAGES_PER_REGION),
    .PAGES_PER_PLANE(PAGES_PER_PLANE), .OP_CYCLES(OP_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .statusRdEn(statusRdEn),
    .ready(ready), .cmdErr(cmdErr), .lockErr(lockErr), .irq(irq),
    .lockState(lockState), .strobe(strobe), .opPage(opPage)
  );

  fcc_datapath #(
    .NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS), .PAGES_PER_PLANE(PAGES_PER_PLANE)
  ) u_data (
    .clk(clk), .rstN(rstN), .bufWrEn(bufWrEn), .bufChunk(bufChunk),
    .bufData(bufData), .strobe(strobe), .opPage(opPage),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  assign status = {lockErr, cmdErr, ready};
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;
  localparam int NP = 16, PW = 16, PPR = 4, PPP = 8, OPC = 6;
  localparam int TOTAL = NP * PW;

  logic clk = 1'b0, rstN = 1'b0;
  logic bufWrEn = 1'b0; logic [1:0] bufChunk = '0; logic [127:0] bufData = '0;
  logic cmdWrEn = 1'b0; logic [31:0] cmdWord = '0;
  logic modeWrEn = 1'b0, modeWrData = 1'b0, statusRdEn = 1'b0;
  logic [2:0] status; logic irq; logic [3:0] lockState;
  logic [7:0] rdAddr = '0; logic [31:0] rdData;

  flash_cmd_ctrl u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] expMem [TOTAL];
  logic [31:0] expBuf [PW];
  logic [3:0]  expLock = '0;
  logic        expCmdErr = 1'b0, expLockErr = 1'b0, expIrqEn = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [7:0] key, input int arg, input logic [7:0] op);
    return {key, arg[15:0], op};
  endfunction

  // 0 accept, 1 command error, 2 lock error (bench view of R1, R4-R7, R12)
  function automatic int decide(input logic [31:0] w);
    int arg; logic planeLk;
    arg = int'(w[23:8]);
    if (w[31:24] != 8'hA5) return 1;
    case (w[7:0])
      8'h01: begin
        if (arg >= NP) return 1;
        return expLock[arg / PPR] ? 2 : 0;
      end
      8'h02: return (|expLock) ? 2 : 0;
      8'h03: begin
        if (arg >= NP / PPP) return 1;
        planeLk = 1'b0;
        for (int r = 0; r < 4; r++) if (expLock[r] && (r * PPR) / PPP == arg) planeLk = 1'b1;
        return planeLk ? 2 : 0;
      end
      8'h04, 8'h05: return (arg >= NP) ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  task automatic applyModel(input logic [31:0] w);
    int arg; arg = int'(w[23:8]);
    case (w[7:0])
      8'h01: begin
        for (int i = 0; i < PW; i++) expMem[arg * PW + i] &= expBuf[i];
        for (int i = 0; i < PW; i++) expBuf[i] = '1;
      end
      8'h02: for (int i = 0; i < TOTAL; i++) expMem[i] = '1;
      8'h03: for (int i = 0; i < PPP * PW; i++) expMem[arg * PPP * PW + i] = '1;
      8'h04: expLock[arg / PPR] = 1'b1;
      8'h05: expLock[arg / PPR] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic loadChunk(input int c, input logic [127:0] d);
    @(negedge clk);
    bufWrEn = 1'b1; bufChunk = 2'(c); bufData = d;
    @(negedge clk);
    bufWrEn = 1'b0;
    for (int i = 0; i < 4; i++) expBuf[c * 4 + i] = d[i * 32 +: 32];
  endtask

  task automatic checkStatus(input string req);
    check(status == {expLockErr, expCmdErr, 1'b1}, req, 32'(status), 32'({expLockErr, expCmdErr, 1'b1}));
  endtask

  // issue a command from idle; checks R8 timing when accepted
  task automatic issue(input logic [31:0] w, input string req);
    int d;
    d = decide(w);
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWord = w;
    @(negedge clk);
    cmdWrEn = 1'b0;
    expCmdErr = (d == 1); expLockErr = (d == 2);
    check(status == {expLockErr, expCmdErr, d != 0}, req, 32'(status), 32'({expLockErr, expCmdErr, d != 0}));
    if (d == 0) begin
      repeat (OPC - 1) @(negedge clk);
      check(status[0] == 1'b0, "R8 ready low through last busy cycle", 32'(status[0]), 32'd0);
      @(negedge clk);
      check(status[0] == 1'b1, "R8 ready high after 6 cycles", 32'(status[0]), 32'd1);
      applyModel(w);
    end
  endtask

  task automatic readStatus(input string req);
    @(negedge clk);
    checkStatus(req);
    statusRdEn = 1'b1;
    @(negedge clk);
    statusRdEn = 1'b0;
    expCmdErr = 1'b0; expLockErr = 1'b0;
  endtask

  task automatic checkArray(input string req);
    int bad; logic [31:0] firstAct, firstExp;
    bad = 0; firstAct = '0; firstExp = '0;
    for (int a = 0; a < TOTAL; a++) begin
      @(negedge clk);
      rdAddr = 8'(a);
      #1;
      if (rdData !== expMem[a]) begin
        if (bad == 0) begin firstAct = rdData; firstExp = expMem[a]; end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
    check(lockState == expLock, "R7 lock state", 32'(lockState), 32'(expLock));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < TOTAL; i++) expMem[i] = '1;
    for (int i = 0; i < PW; i++) expBuf[i] = '1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R3, R10, R9)
    check(status == 3'b001, "R10 reset status", 32'(status), 32'd1);
    check(irq == 1'b0, "R9 irq off after reset", 32'(irq), 32'd0);
    checkArray("R3 array erased at reset");

    // R2/R3 partial programming in two steps on page 3
    loadChunk(0, {32'hDECA0003, 32'hCAFE0002, 32'hCAFE0001, 32'hCAFE0000});
    issue(mkCmd(8'hA5, 3, 8'h01), "R2 program step one");
    checkArray("R2 R3 first chunk programmed");
    loadChunk(2, {32'h0F0F0F0F, 32'h12345678, 32'hFFFF0000, 32'h00FFFFFF});
    issue(mkCmd(8'hA5, 3, 8'h01), "R2 program step two");
    checkArray("R2 second chunk programmed, first kept");

    // R1 bad key
    issue(mkCmd(8'h5A, 4, 8'h02), "R1 bad key rejected");
    checkArray("R1 bad key changes nothing");
    readStatus("R10 status before clear");
    @(negedge clk);
    checkStatus("R10 errors cleared by status read");

    // R12 bad opcode / range
    issue(mkCmd(8'hA5, 1, 8'h09), "R12 unknown opcode");
    issue(mkCmd(8'hA5, 16, 8'h01), "R12 page out of range");
    issue(mkCmd(8'hA5, 2, 8'h03), "R12 plane out of range");
    checkArray("R12 no change");

    // R7 lock region 1, R4 R5 R6 rejections
    issue(mkCmd(8'hA5, 5, 8'h04), "R7 lock region 1");
    check(lockState == 4'b0010, "R7 region 1 locked", 32'(lockState), 32'h2);
    loadChunk(1, 128'h0);
    issue(mkCmd(8'hA5, 6, 8'h01), "R4 program locked page");
    issue(mkCmd(8'hA5, 0, 8'h02), "R5 erase-all while locked");
    issue(mkCmd(8'hA5, 0, 8'h03), "R6 erase plane 0 with lock");
    checkArray("R4 locked page untouched");
    loadChunk(3, {4{32'h00000055}});
    issue(mkCmd(8'hA5, 12, 8'h01), "R2 program page 12");
    issue(mkCmd(8'hA5, 1, 8'h03), "R6 erase plane 1 allowed");
    checkArray("R6 plane 1 erased");
    issue(mkCmd(8'hA5, 7, 8'h05), "R7 unlock region 1");
    issue(mkCmd(8'hA5, 0, 8'h01), "R2 program page 0");
    issue(mkCmd(8'hA5, 0, 8'h02), "R5 erase-all unlocked");
    checkArray("R5 all erased");

    // R10 new command replaces old errors
    issue(mkCmd(8'h00, 0, 8'h01), "R10 make error");
    issue(mkCmd(8'hA5, 9, 8'h04), "R10 good command clears errors");
    issue(mkCmd(8'hA5, 9, 8'h05), "R7 unlock region 2");

    // R9 interrupt
    @(negedge clk); modeWrEn = 1'b1; modeWrData = 1'b1;
    @(negedge clk); modeWrEn = 1'b0; expIrqEn = 1'b1;
    check(irq == 1'b1, "R9 irq when ready and enabled", 32'(irq), 32'd1);
    @(negedge clk); cmdWrEn = 1'b1; cmdWord = mkCmd(8'hA5, 2, 8'h04);
    @(negedge clk); cmdWrEn = 1'b0;
    check(irq == 1'b0, "R9 irq low while busy", 32'(irq), 32'd0);
    repeat (OPC) @(negedge clk);
    check(irq == 1'b1, "R9 irq on ready rise", 32'(irq), 32'd1);
    applyModel(mkCmd(8'hA5, 2, 8'h04));
    issue(mkCmd(8'hA5, 2, 8'h05), "R7 unlock region 0");

    // R11 command while busy
    loadChunk(1, {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444});
    @(negedge clk); cmdWrEn = 1'b1; cmdWord = mkCmd(8'hA5, 2, 8'h01);
    @(negedge clk); cmdWord = mkCmd(8'hA5, 0, 8'h02);
    @(negedge clk); cmdWrEn = 1'b0;
    check(status == 3'b010, "R11 busy command flagged", 32'(status), 32'h2);
    repeat (OPC - 1) @(negedge clk);
    check(status[0] == 1'b1, "R11 running operation finished", 32'(status[0]), 32'd1);
    applyModel(mkCmd(8'hA5, 2, 8'h01));
    expCmdErr = 1'b1; expLockErr = 1'b0;
    checkArray("R11 ignored erase had no effect");
    readStatus("R11 status after busy write");

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int kind; kind = int'($urandom % 10);
      if (kind < 3) begin
        loadChunk(int'($urandom % 4), {$urandom, $urandom, $urandom, $urandom});
      end else if (kind == 3) begin
        readStatus("R10 random status read");
      end else begin
        logic [7:0] key, op; int arg, sel;
        key = ($urandom % 8 == 0) ? 8'(($urandom % 255) + 1) ^ 8'hA5 : 8'hA5;
        sel = int'($urandom % 12);
        op  = (sel < 5) ? 8'h01 : (sel == 5) ? 8'h02 : (sel == 6) ? 8'h03 :
              (sel < 9) ? 8'h04 : (sel < 11) ? 8'h05 : 8'h07;
        arg = (op == 8'h03) ? int'($urandom % 3) : int'($urandom % (NP + 2));
        issue(mkCmd(key, arg, op), "R1 R2 R5 R6 R7 R12 random command");
        checkArray("R2 R4 random array compare");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule